// File: doc/BRIEF.md
# Condition Register Logic Unit

This block keeps a 32-bit condition register made of eight 4-bit fields. Beside it sits a three-bit status group taken from a fixed-point exception register: summary-overflow, overflow and carry. Each cycle it takes at most one command. A command can write the condition register in full or field by field under a mask, or read it without changing it. It can combine two condition bits with one of eight boolean functions and store the result in a third bit. It can also copy one field over another, load the status group, or move the status group into a field and clear the status group in the same step.

Condition bits and fields are numbered from the most significant end: bit 0 is bit 31 of the vector and field 0 is its top nibble. Both registers are visible on the outputs at all times. A command takes effect on the rising clock edge at which `cmd_valid` is high. Instruction decode, pipelining and branch evaluation are left to the surrounding core.

Top module: `crlu_top`

## Requirements
- R1: With valid high and opcode 1 (full write), `cr_out` equals `wr_data` after the edge. This holds for 0xAAAAAAAA and 0x55555555.
- R2: Opcode 2 (masked write) replaces each field whose mask bit is set with the matching nibble of `wr_data`. Mask bit k covers vector bits 4k+3..4k, so mask bit 7 selects field 0. Fields whose mask bit is clear keep their value.
- R3: Opcodes 8..15 store f(bit A, bit B) into bit D, where bit index i means vector bit 31-i. The functions are: 8 AND, 9 A&~B, 10 OR, 11 A|~B, 12 XOR, 13 NAND, 14 NOR, 15 XNOR. For example, with 0x0000FFFF, ANDing bits 16 and 17 into bit 0 gives 0x8000FFFF.
- R4: A bit operation changes no bit other than bit D, and it leaves the status group unchanged.
- R5: Opcode 3 copies field `fld_src` into field `fld_dst`. From 0x01234567, copying 0 to 4 gives 0x01230567, and copying 7 to 0 gives 0x71234567.
- R6: Opcode 4 writes {SO, OV, CA, 0} into field `fld_dst` and clears SO, OV and CA. After this `xer_out` reads zero.
- R7: Opcode 0 (read) and the unused opcodes 6 and 7 change neither register.
- R8: Opcode 5 loads SO, OV and CA from `wr_data[31:29]`. `xer_out` shows them in bits 31..29, and its other bits are always zero.
- R9: With `cmd_valid` low, neither register changes.
- R10: Synchronous reset clears both registers to zero.
- R11: When a bit operation reads bit D as a source, it uses the value bit D had before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 4 | Opcode |
| bit_a | input | 5 | First source bit index (0 = MSB) |
| bit_b | input | 5 | Second source bit index |
| bit_d | input | 5 | Destination bit index |
| fld_src | input | 3 | Source field index (0 = top nibble) |
| fld_dst | input | 3 | Destination field index |
| fld_mask | input | 8 | Field mask for masked writes |
| wr_data | input | 32 | Write data |
| cr_out | output | 32 | Condition register |
| xer_out | output | 32 | Exception register status view |

## Verification
Both registers drive the ports directly, so a wrong internal bit appears on `cr_out` or `xer_out` in the first half-cycle after the faulty edge. The bench compares both outputs with a behavioural model at every falling edge, so a misrouted index, a wrong boolean function, or a stray write to a neighbouring field is reported in the same cycle. A status group that is not cleared, or a bit operation that reads the value it has just written, diverges from the model at once and stays wrong until the next write covers it.

// File: rtl/crlu_pkg.sv
package crlu_pkg;

   typedef enum logic [3:0] {
      OP_READ    = 4'h0,
      OP_WR_ALL  = 4'h1,
      OP_WR_MASK = 4'h2,
      OP_FCOPY   = 4'h3,
      OP_XMOVE   = 4'h4,
      OP_XLOAD   = 4'h5,
      OP_AND     = 4'h8,
      OP_ANDC    = 4'h9,
      OP_OR      = 4'hA,
      OP_ORC     = 4'hB,
      OP_XOR     = 4'hC,
      OP_NAND    = 4'hD,
      OP_NOR     = 4'hE,
      OP_EQV     = 4'hF
   } crlu_op_e;

   typedef enum logic [2:0] {
      FN_AND  = 3'd0,
      FN_ANDC = 3'd1,
      FN_OR   = 3'd2,
      FN_ORC  = 3'd3,
      FN_XOR  = 3'd4,
      FN_NAND = 3'd5,
      FN_NOR  = 3'd6,
      FN_EQV  = 3'd7
   } crlu_fn_e;

endpackage

// File: rtl/crlu_bitop.sv
module crlu_bitop
   import crlu_pkg::*;
(
   input  logic       a,
   input  logic       b,
   input  logic [2:0] fn,
   output logic       y
);
   always_comb begin
      case (crlu_fn_e'(fn))
         FN_AND:  y = a & b;
         FN_ANDC: y = a & ~b;
         FN_OR:   y = a | b;
         FN_ORC:  y = a | ~b;
         FN_XOR:  y = a ^ b;
         FN_NAND: y = ~(a & b);
         FN_NOR:  y = ~(a | b);
         default: y = ~(a ^ b);
      endcase
   end
endmodule

// File: rtl/crlu_field_pick.sv
module crlu_field_pick #(
   parameter int FIELDS     = 8,
   parameter int FIELD_W    = 4,
   parameter bit BIG_ENDIAN = 1'b1,
   localparam int VEC_W     = FIELDS * FIELD_W,
   localparam int FIDX_W    = $clog2(FIELDS)
) (
   input  logic [VEC_W-1:0]   vec,
   input  logic [FIDX_W-1:0]  idx,
   output logic [FIELD_W-1:0] nib
);
   logic [FIDX_W-1:0] pos;

   generate
      if (BIG_ENDIAN) begin : g_msb_first
         assign pos = FIDX_W'(FIELDS - 1) - idx;
      end else begin : g_lsb_first
         assign pos = idx;
      end
   endgenerate

   assign nib = vec[pos*FIELD_W +: FIELD_W];
endmodule

// File: rtl/crlu_top.sv
module crlu_top
   import crlu_pkg::*;
#(
   parameter int FIELDS     = 8,
   parameter int FIELD_W    = 4,
   parameter bit BIG_ENDIAN = 1'b1,
   parameter int XER_W      = 32,
   localparam int CR_W      = FIELDS * FIELD_W,
   localparam int BIDX_W    = $clog2(CR_W),
   localparam int FIDX_W    = $clog2(FIELDS)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cmd_valid,
   input  logic [3:0]        cmd_op,
   input  logic [BIDX_W-1:0] bit_a,
   input  logic [BIDX_W-1:0] bit_b,
   input  logic [BIDX_W-1:0] bit_d,
   input  logic [FIDX_W-1:0] fld_src,
   input  logic [FIDX_W-1:0] fld_dst,
   input  logic [FIELDS-1:0] fld_mask,
   input  logic [CR_W-1:0]   wr_data,
   output logic [CR_W-1:0]   cr_out,
   output logic [XER_W-1:0]  xer_out
);
   // elaboration checks on the parameter set
   generate
      if (FIELD_W < 4) begin : g_bad_fw
         $error("crlu_top: FIELD_W must be at least 4");
      end
      if ((FIELDS < 2) || ((FIELDS & (FIELDS - 1)) != 0)) begin : g_bad_nf
         $error("crlu_top: FIELDS must be a power of two");
      end
      if ((XER_W < 3) || (XER_W > CR_W)) begin : g_bad_xw
         $error("crlu_top: XER_W out of range");
      end
   endgenerate

   crlu_op_e op;
   assign op = crlu_op_e'(cmd_op);

   logic [CR_W-1:0]   cr_q, cr_d, cr_bit;
   logic [2:0]        xs_q, xs_d;   // {SO, OV, CA}
   logic [BIDX_W-1:0] pa, pb, pd;
   logic              src_a, src_b, bit_y;
   logic [FIELD_W-1:0] copy_nib, xs_nib;
   logic              is_bitop;

   // index-to-vector-position mapping
   generate
      if (BIG_ENDIAN) begin : g_bit_msb
         assign pa = BIDX_W'(CR_W - 1) - bit_a;
         assign pb = BIDX_W'(CR_W - 1) - bit_b;
         assign pd = BIDX_W'(CR_W - 1) - bit_d;
      end else begin : g_bit_lsb
         assign pa = bit_a;
         assign pb = bit_b;
         assign pd = bit_d;
      end
   endgenerate

   assign is_bitop = cmd_op[3];
   assign src_a    = cr_q[pa];
   assign src_b    = cr_q[pb];

   crlu_bitop u_bitop (
      .a  (src_a),
      .b  (src_b),
      .fn (cmd_op[2:0]),
      .y  (bit_y)
   );

   always_comb begin
      cr_bit     = cr_q;
      cr_bit[pd] = bit_y;
   end

   crlu_field_pick #(
      .FIELDS     (FIELDS),
      .FIELD_W    (FIELD_W),
      .BIG_ENDIAN (BIG_ENDIAN)
   ) u_copy_src (
      .vec (cr_q),
      .idx (fld_src),
      .nib (copy_nib)
   );

   assign xs_nib = {xs_q, {(FIELD_W-3){1'b0}}};

   // per-nibble next-state selection
   generate
      for (genvar p = 0; p < FIELDS; p++) begin : g_nib
         localparam int FIDX = BIG_ENDIAN ? (FIELDS - 1 - p) : p;
         localparam logic [FIDX_W-1:0] FSEL = FIDX_W'(FIDX);
         logic [FIELD_W-1:0] cur, nxt;
         assign cur = cr_q[p*FIELD_W +: FIELD_W];
         always_comb begin
            nxt = cur;
            case (op)
               OP_WR_ALL:  nxt = wr_data[p*FIELD_W +: FIELD_W];
               OP_WR_MASK: if (fld_mask[p]) nxt = wr_data[p*FIELD_W +: FIELD_W];
               OP_FCOPY:   if (fld_dst == FSEL) nxt = copy_nib;
               OP_XMOVE:   if (fld_dst == FSEL) nxt = xs_nib;
               default:    if (is_bitop) nxt = cr_bit[p*FIELD_W +: FIELD_W];
            endcase
         end
         assign cr_d[p*FIELD_W +: FIELD_W] = nxt;
      end
   endgenerate

   always_comb begin
      xs_d = xs_q;
      if (op == OP_XLOAD)      xs_d = wr_data[CR_W-1 -: 3];
      else if (op == OP_XMOVE) xs_d = 3'b000;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cr_q <= '0;
         xs_q <= '0;
      end else if (cmd_valid) begin
         cr_q <= cr_d;
         xs_q <= xs_d;
      end
   end

   assign cr_out  = cr_q;
   assign xer_out = {xs_q, {(XER_W-3){1'b0}}};

   // ---------------- assertions ----------------
   AST_RESET_CLEARS: assert property (@(posedge clk)
      rst |=> (cr_out == '0) && (xer_out == '0)); // R10

   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
      !cmd_valid |=> $stable(cr_out) && $stable(xer_out)); // R9

   AST_BITOP_SINGLE: assert property (@(posedge clk) disable iff (rst)
      (cmd_valid && is_bitop) |=>
         ($countones(cr_out ^ $past(cr_out)) <= 1) && $stable(xer_out)); // R4

   AST_BITOP_DEST: assert property (@(posedge clk) disable iff (rst)
      (cmd_valid && is_bitop) |=> cr_out[$past(pd)] == $past(bit_y)); // R3

   AST_XMOVE_CLEARS: assert property (@(posedge clk) disable iff (rst)
      (cmd_valid && op == OP_XMOVE) |=> xer_out == '0); // R6

   AST_READ_NOCHANGE: assert property (@(posedge clk) disable iff (rst)
      (cmd_valid && (cmd_op == 4'h0 || cmd_op == 4'h6 || cmd_op == 4'h7))
         |=> $stable(cr_out) && $stable(xer_out)); // R7

   AST_FULL_WRITE: assert property (@(posedge clk) disable iff (rst)
      (cmd_valid && op == OP_WR_ALL) |=> cr_out == $past(wr_data)); // R1

endmodule

// File: tb/crlu_top_bench.sv
module crlu_top_bench;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cmd_valid = 1'b0;
   logic [3:0]  cmd_op = 4'h0;
   logic [4:0]  bit_a = '0, bit_b = '0, bit_d = '0;
   logic [2:0]  fld_src = '0, fld_dst = '0;
   logic [7:0]  fld_mask = '0;
   logic [31:0] wr_data = '0;
   logic [31:0] cr_out, xer_out;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   string cur_req = "R10";
   string last_req = "R10";

   logic [31:0] m_cr = '0;
   logic [2:0]  m_xs = '0;

   always #10 clk = ~clk;   // 50 MHz

   crlu_top u_crlu_top (
      .clk, .rst, .cmd_valid, .cmd_op, .bit_a, .bit_b, .bit_d,
      .fld_src, .fld_dst, .fld_mask, .wr_data, .cr_out, .xer_out
   );

   function automatic logic fn_eval(int code, logic a, logic b);
      case (code)
         8:  return a & b;
         9:  return a & !b;
         10: return a | b;
         11: return a | !b;
         12: return a ^ b;
         13: return !(a & b);
         14: return !(a | b);
         default: return !(a ^ b);
      endcase
   endfunction

   // behavioural reference model
   always @(posedge clk) begin
      logic [31:0] nc;
      logic [2:0]  nx;
      nc = m_cr;
      nx = m_xs;
      if (rst) begin
         nc = '0;
         nx = '0;
      end else if (cmd_valid) begin
         int op;
         op = int'(cmd_op);
         if (op == 1) nc = wr_data;
         else if (op == 2) begin
            for (int k = 0; k < 8; k++)
               if (fld_mask[k]) nc[4*k +: 4] = wr_data[4*k +: 4];
         end else if (op == 3) begin
            nc[4*(7 - int'(fld_dst)) +: 4] = m_cr[4*(7 - int'(fld_src)) +: 4];
         end else if (op == 4) begin
            nc[4*(7 - int'(fld_dst)) +: 4] = {m_xs, 1'b0};
            nx = '0;
         end else if (op == 5) nx = wr_data[31:29];
         else if (op >= 8) begin
            nc[31 - int'(bit_d)] = fn_eval(op, m_cr[31 - int'(bit_a)], m_cr[31 - int'(bit_b)]);
         end
      end
      m_cr <= nc;
      m_xs <= nx;
      last_req <= cur_req;
   end

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (!done) begin
         checks++;
         if (cr_out !== m_cr || xer_out !== {m_xs, 29'b0}) begin
            errors++;
            $display("FAIL %s: cr=%h xer=%h expected cr=%h xer=%h",
                     last_req, cr_out, xer_out, m_cr, {m_xs, 29'b0});
         end
      end
   end

   task automatic cmd(input logic [3:0] op, input logic [4:0] a, input logic [4:0] b,
                      input logic [4:0] d, input logic [2:0] s, input logic [2:0] t,
                      input logic [7:0] m, input logic [31:0] data, input string req);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; bit_a = a; bit_b = b; bit_d = d;
      fld_src = s; fld_dst = t; fld_mask = m; wr_data = data; cur_req = req;
   endtask

   task automatic expect_now(input logic [31:0] cr_exp, input logic [31:0] xer_exp,
                             input string req);
      @(negedge clk);
      cmd_valid = 1'b0;
      cmd_op = 4'h0;
      checks++;
      if (cr_out !== cr_exp || xer_out !== xer_exp) begin
         errors++;
         $display("FAIL %s: cr=%h xer=%h expected cr=%h xer=%h",
                  req, cr_out, xer_out, cr_exp, xer_exp);
      end
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not complete");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      expect_now(32'h0, 32'h0, "R10");

      // R1 full write and alternating patterns
      cmd(4'h1, 0, 0, 0, 0, 0, 0, 32'hAAAAAAAA, "R1");
      expect_now(32'hAAAAAAAA, 32'h0, "R1");
      cmd(4'h1, 0, 0, 0, 0, 0, 0, 32'h55555555, "R1");
      expect_now(32'h55555555, 32'h0, "R1");

      // R7 read and unused opcodes
      cmd(4'h0, 0, 0, 0, 0, 0, 0, 32'hFFFFFFFF, "R7");
      cmd(4'h6, 0, 0, 0, 0, 0, 0, 32'hFFFFFFFF, "R7");
      cmd(4'h7, 0, 0, 0, 0, 0, 0, 32'hFFFFFFFF, "R7");
      expect_now(32'h55555555, 32'h0, "R7");

      // R9 valid low ignores a write command
      @(negedge clk);
      cmd_valid = 1'b0; cmd_op = 4'h1; wr_data = 32'h12345678; cur_req = "R9";
      expect_now(32'h55555555, 32'h0, "R9");

      // R2 masked write: mask bits 7 and 0 select fields 0 and 7
      cmd(4'h1, 0, 0, 0, 0, 0, 0, 32'h01234567, "R1");
      cmd(4'h2, 0, 0, 0, 0, 0, 8'h81, 32'hFFFFFFFF, "R2");
      expect_now(32'hF123456F, 32'h0, "R2");

      // R5 field copies
      cmd(4'h1, 0, 0, 0, 0, 0, 0, 32'h01234567, "R1");
      cmd(4'h3, 0, 0, 0, 3'd0, 3'd4, 0, 0, "R5");
      expect_now(32'h01230567, 32'h0, "R5");
      cmd(4'h1, 0, 0, 0, 0, 0, 0, 32'h01234567, "R1");
      cmd(4'h3, 0, 0, 0, 3'd7, 3'd0, 0, 0, "R5");
      expect_now(32'h71234567, 32'h0, "R5");

      // R8 / R6 status load and move-with-clear
      cmd(4'h1, 0, 0, 0, 0, 0, 0, 32'h0, "R1");
      cmd(4'h5, 0, 0, 0, 0, 0, 0, 32'hA0000000, "R8");
      expect_now(32'h0, 32'hA0000000, "R8");
      cmd(4'h4, 0, 0, 0, 0, 3'd1, 0, 0, "R6");
      expect_now(32'h0A000000, 32'h0, "R6");
      cmd(4'h5, 0, 0, 0, 0, 0, 0, 32'h5FFFFFFF, "R8");
      expect_now(32'h0A000000, 32'h40000000, "R8");
      cmd(4'h4, 0, 0, 0, 0, 3'd5, 0, 0, "R6");
      expect_now(32'h0A000400, 32'h0, "R6");

      // R3 / R4 the eight functions on 0x0000FFFF, two vectors each
      begin
         logic [3:0]  t_op [16] = '{4'h8,4'h8,4'h9,4'h9,4'hA,4'hA,4'hB,4'hB,
                                    4'hC,4'hC,4'hD,4'hD,4'hE,4'hE,4'hF,4'hF};
         logic [4:0]  t_a  [16] = '{0,16,0,16,0,0,0,0,0,0,0,16,0,0,0,0};
         logic [4:0]  t_b  [16] = '{16,17,16,0,16,1,16,0,0,16,16,17,16,1,0,16};
         logic [31:0] t_r  [16] = '{32'h0000FFFF,32'h8000FFFF,32'h0000FFFF,32'h8000FFFF,
                                    32'h8000FFFF,32'h0000FFFF,32'h0000FFFF,32'h8000FFFF,
                                    32'h0000FFFF,32'h8000FFFF,32'h8000FFFF,32'h0000FFFF,
                                    32'h0000FFFF,32'h8000FFFF,32'h8000FFFF,32'h0000FFFF};
         for (int i = 0; i < 16; i++) begin
            cmd(4'h1, 0, 0, 0, 0, 0, 0, 32'h0000FFFF, "R1");
            cmd(t_op[i], t_a[i], t_b[i], 5'd0, 0, 0, 0, 0, "R3");
            expect_now(t_r[i], 32'h0, "R3 R4");
         end
      end

      // R11 destination also a source: NOR of bit 0 with itself toggles it
      cmd(4'h1, 0, 0, 0, 0, 0, 0, 32'h80000000, "R1");
      cmd(4'hE, 5'd0, 5'd0, 5'd0, 0, 0, 0, 0, "R11");
      expect_now(32'h00000000, 32'h0, "R11");
      cmd(4'hE, 5'd0, 5'd0, 5'd0, 0, 0, 0, 0, "R11");
      expect_now(32'h80000000, 32'h0, "R11");
      cmd(4'hC, 5'd31, 5'd0, 5'd31, 0, 0, 0, 0, "R11");
      expect_now(32'h80000001, 32'h0, "R11");

      // random traffic against the model (R3 R4 R5 R6 R9)
      for (int n = 0; n < 400; n++) begin
         logic [3:0] rop;
         rop = 4'($urandom_range(0, 15));
         cmd(rop, 5'($urandom), 5'($urandom), 5'($urandom), 3'($urandom), 3'($urandom),
             8'($urandom), $urandom, "R4");
         cmd_valid = ($urandom_range(0, 5) != 0);
      end

      // R10 reset mid-run
      cmd(4'h5, 0, 0, 0, 0, 0, 0, 32'hE0000000, "R8");
      cmd(4'h1, 0, 0, 0, 0, 0, 0, 32'hDEADBEEF, "R1");
      @(negedge clk);
      cmd_valid = 1'b0; rst = 1'b1; cur_req = "R10";
      @(negedge clk);
      rst = 1'b0;
      expect_now(32'h0, 32'h0, "R10");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule